// File: doc/BRIEF.md
# Second Order Noise Shaping Requantiser

This block sits between the interpolation stage and a 12-bit converter core. Each cycle with a valid input, it takes a 16-bit sample and emits a 12-bit sample one clock later. The input may arrive as offset binary or as two's complement, and a format control selects which. The output is always two's complement.

With shaping enabled, the block keeps the last two quantisation errors and feeds them back. The next value to be quantised is therefore the new sample plus twice the previous error minus the error before that. This gives the error a (1 - z^-1)^2 transfer, so most of the requantisation noise moves toward the upper end of the band. With shaping disabled, the sample is simply rounded to 12 bits with saturation, and the error history is cleared.

The stored error is held at extended precision and saturated to a bounded width. This keeps the loop stable when the output clips at full scale.

Top module: `ns_requant`

## Requirements
- R1: With fmt_offset_i=1 the input is offset binary and is turned into two's complement by inverting bit 15; with fmt_offset_i=0 it is taken as two's complement unchanged.
- R2: data_o is a 12-bit two's complement word.
- R3: With shape_en_i=0, data_o = floor((x + 8) / 16), where x is the two's complement input.
- R4: The quantised result is saturated to the range [-2048, 2047], so 0x7FFF gives 0x7FF and 0x8000 (two's complement) gives 0x800.
- R5: With shape_en_i=1, the quantised value is v = x + 2*e1 - e2, where e1 is the newest stored error and e2 the one before it, and data_o = saturate(floor((v + 8) / 16)).
- R6: With shaping on, each valid sample stores the error e = v - 16*data_o, saturated to [-128, 127], as the new e1, and the old e1 moves to e2. Cycles without valid_i leave both stored errors unchanged.
- R7: Any clock edge with shape_en_i=0 clears both stored errors, whether or not valid_i is high. A sample taken after shaping is re-enabled uses zero history.
- R8: valid_o equals valid_i delayed by exactly one clock, and data_o carries the result of the sample accepted on that edge.
- R9: data_o holds its value on edges where valid_i is low.
- R10: While rst_ni is low, valid_o and data_o are 0 and the error history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shape_en_i | input | 1 | 1 enables error feedback shaping |
| fmt_offset_i | input | 1 | 1 selects offset binary input, 0 selects two's complement |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 16 | Input sample |
| valid_o | output | 1 | Output sample strobe, one clock after valid_i |
| data_o | output | 12 | Requantised two's complement sample |

## Verification
The bench runs a bit-exact error feedback model and applies several kinds of input. Directed extremes at both full-scale ends separate correct saturation from wraparound. Values of ±8 around zero separate round-to-nearest from truncation, and offset-binary midscale checks the MSB inversion. A long constant DC input with shaping on produces a repeating error pattern that a first-order or non-shaped requantiser cannot match. Random bursts with gaps in valid_i, and enable toggles made in cycles without a sample, show that the history advances only on accepted samples and is cleared whenever shaping is off.

// File: rtl/ns_requant_pkg.sv
package ns_requant_pkg;
  localparam int unsigned IN_W_DEF  = 16;
  localparam int unsigned OUT_W_DEF = 12;
  localparam int unsigned ERR_W_DEF = 8;

  // width of the feedback sum: input plus two guard bits
  function automatic int unsigned sum_width(int unsigned in_w);
    return in_w + 2;
  endfunction
endpackage

// File: rtl/ns_fmt_conv.sv
module ns_fmt_conv #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]        raw_i,
  input  logic                offset_i,
  output logic signed [W-1:0] tc_o
);
  always_comb begin
    if (offset_i) tc_o = {~raw_i[W-1], raw_i[W-2:0]};
    else          tc_o = raw_i;
  end
endmodule

// File: rtl/ns_err_fb.sv
module ns_err_fb #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ERR_W = 8,
  parameter int unsigned VW    = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    adv_i,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic signed [ERR_W-1:0] err_new_i,
  output logic signed [VW-1:0]    v_o,
  output logic signed [ERR_W-1:0] err1_o,
  output logic signed [ERR_W-1:0] err2_o
);
  logic signed [ERR_W-1:0] e1_q, e2_q;
  logic signed [VW-1:0]    x_ext, e1_ext, e2_ext;

  assign x_ext  = VW'(x_i);
  assign e1_ext = VW'(e1_q);
  assign e2_ext = VW'(e2_q);

  // gate with en so a freshly disabled cycle never sees stale history
  always_comb begin
    if (en_i) v_o = x_ext + (e1_ext <<< 1) - e2_ext;
    else      v_o = x_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e1_q <= '0;
      e2_q <= '0;
    end else if (!en_i) begin
      e1_q <= '0;
      e2_q <= '0;
    end else if (adv_i) begin
      e2_q <= e1_q;
      e1_q <= err_new_i;
    end
  end

  assign err1_o = e1_q;
  assign err2_o = e2_q;
endmodule

// File: rtl/ns_quant.sv
module ns_quant #(
  parameter int unsigned VW    = 18,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned SH    = 4,
  parameter int unsigned ERR_W = 8
) (
  input  logic signed [VW-1:0]    v_i,
  output logic signed [OUT_W-1:0] q_o,
  output logic signed [ERR_W-1:0] err_o
);
  localparam int unsigned XW = VW + 1;
  localparam logic signed [XW-1:0] HALF = XW'(1 << (SH - 1));
  localparam logic signed [XW-1:0] QMAX = XW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [XW-1:0] QMIN = -QMAX - XW'(1);
  localparam logic signed [XW-1:0] EMAX = XW'((1 << (ERR_W - 1)) - 1);
  localparam logic signed [XW-1:0] EMIN = -EMAX - XW'(1);

  logic signed [XW-1:0] v_ext, v_rnd, r_sh, q_sat, diff;

  always_comb begin
    v_ext = XW'(v_i);
    v_rnd = v_ext + HALF;
    r_sh  = v_rnd >>> SH;
    if (r_sh > QMAX)      q_sat = QMAX;
    else if (r_sh < QMIN) q_sat = QMIN;
    else                  q_sat = r_sh;
    // error relative to the clipped level
    diff = v_ext - (q_sat <<< SH);
    if (diff > EMAX)      err_o = EMAX[ERR_W-1:0];
    else if (diff < EMIN) err_o = EMIN[ERR_W-1:0];
    else                  err_o = diff[ERR_W-1:0];
    q_o = q_sat[OUT_W-1:0];
  end
endmodule

// File: rtl/ns_requant.sv
module ns_requant #(
  parameter int unsigned IN_W  = ns_requant_pkg::IN_W_DEF,
  parameter int unsigned OUT_W = ns_requant_pkg::OUT_W_DEF,
  parameter int unsigned ERR_W = ns_requant_pkg::ERR_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shape_en_i,
  input  logic             fmt_offset_i,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);
  localparam int unsigned SH = IN_W - OUT_W;
  localparam int unsigned VW = ns_requant_pkg::sum_width(IN_W);

  logic signed [IN_W-1:0]  x_tc;
  logic signed [VW-1:0]    v_sum;
  logic signed [OUT_W-1:0] q_val;
  logic signed [ERR_W-1:0] err_new, err1, err2;

  ns_fmt_conv #(.W(IN_W)) u_fmt (
    .raw_i    (data_i),
    .offset_i (fmt_offset_i),
    .tc_o     (x_tc)
  );

  ns_err_fb #(.IN_W(IN_W), .ERR_W(ERR_W), .VW(VW)) u_fb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (shape_en_i),
    .adv_i     (valid_i),
    .x_i       (x_tc),
    .err_new_i (err_new),
    .v_o       (v_sum),
    .err1_o    (err1),
    .err2_o    (err2)
  );

  ns_quant #(.VW(VW), .OUT_W(OUT_W), .SH(SH), .ERR_W(ERR_W)) u_q (
    .v_i   (v_sum),
    .q_o   (q_val),
    .err_o (err_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= q_val;
    end
  end
endmodule

// File: rtl/ns_requant_chk.sv
module ns_requant_chk #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 12,
  parameter int unsigned ERR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shape_en_i,
  input logic             fmt_offset_i,
  input logic             valid_i,
  input logic [IN_W-1:0]  data_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o,
  input logic [ERR_W-1:0] err1,
  input logic [ERR_W-1:0] err2
);
  assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

  assert_sat_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !shape_en_i && !fmt_offset_i && data_i == {1'b0, {(IN_W-1){1'b1}}}
    |=> data_o == {1'b0, {(OUT_W-1){1'b1}}});

  assert_offset_mid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !shape_en_i && fmt_offset_i && data_i == {1'b1, {(IN_W-1){1'b0}}}
    |=> data_o == '0);

  assert_clear_hist_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shape_en_i |=> err1 == '0 && err2 == '0);

  assert_hist_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shape_en_i && !valid_i |=> $stable(err1) && $stable(err2));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_R10: assert (!valid_o && data_o == '0);
    end
  end
endmodule

bind ns_requant ns_requant_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .ERR_W(ERR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .shape_en_i   (shape_en_i),
  .fmt_offset_i (fmt_offset_i),
  .valid_i      (valid_i),
  .data_i       (data_i),
  .valid_o      (valid_o),
  .data_o       (data_o),
  .err1         (err1),
  .err2         (err2)
);

// File: tb/ns_requant_tb_top.sv
module ns_requant_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        shape_en_i = 1'b0;
  logic        fmt_offset_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        valid_o;
  logic [11:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_e1 = 0, m_e2 = 0;
  int exp_d = 0;

  always #5 clk_i = ~clk_i;

  ns_requant dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .shape_en_i(shape_en_i),
    .fmt_offset_i(fmt_offset_i), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  function automatic int rnd_sat(int v);
    int r;
    r = (v + 8) >>> 4;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  function automatic int to_tc(logic [15:0] d, logic off);
    logic [15:0] t;
    t = off ? (d ^ 16'h8000) : d;
    return int'($signed(t));
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply one cycle, update model, compare after the edge
  task automatic step(bit en, bit off, bit vld, logic [15:0] d, string req);
    int x, v, q, e;
    @(negedge clk_i);
    shape_en_i = en; fmt_offset_i = off; valid_i = vld; data_i = d;
    x = to_tc(d, off);
    v = en ? x + 2 * m_e1 - m_e2 : x;
    q = rnd_sat(v);
    e = v - 16 * q;
    if (e > 127) e = 127;
    if (e < -128) e = -128;
    if (!en) begin m_e1 = 0; m_e2 = 0; end
    else if (vld) begin m_e2 = m_e1; m_e1 = e; end
    if (vld) exp_d = q;
    @(posedge clk_i); #1;
    check({req, "/R8"}, int'(valid_o), int'(vld));
    check(req, int'($signed(data_o)), exp_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk_i);
    #1;
    check("R10 valid", int'(valid_o), 0);
    check("R10 data", int'(data_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // rounding and saturation with shaping off
    step(0, 0, 1, 16'h0008, "R3 +8");
    step(0, 0, 1, 16'hFFF8, "R3 -8");
    step(0, 0, 1, 16'h0017, "R3 23");
    step(0, 0, 1, 16'h7FFF, "R4 max");
    step(0, 0, 1, 16'h8000, "R4 min");
    step(0, 1, 1, 16'h8000, "R1 mid");
    step(0, 1, 1, 16'hFFFF, "R1 top");
    step(0, 1, 1, 16'h0000, "R1 bottom");
    step(0, 0, 0, 16'h1234, "R9 idle");

    // DC input with shaping on
    for (int i = 0; i < 64; i++) step(1, 0, 1, 16'h0123, "R5 dc");
    for (int i = 0; i < 16; i++) step(1, 0, 1, 16'h7FFF, "R6 clip");
    step(1, 0, 0, 16'h4000, "R6 gap");
    step(1, 0, 1, 16'h0005, "R6 after gap");
    step(0, 0, 0, 16'h0000, "R7 off idle");
    step(1, 0, 1, 16'h0005, "R7 fresh");
    step(1, 1, 1, 16'h8009, "R1 R5 offset");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      int unsigned k;
      k = $urandom % 8;
      d = 16'($urandom);
      if (k == 0) d = 16'h7FF0 | 16'($urandom % 16);
      if (k == 1) d = 16'h8000 | 16'($urandom % 16);
      step(($urandom % 16) != 0, ($urandom % 4) == 0, ($urandom % 5) != 0, d, "R2 R5 rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule